// File: doc/BRIEF.md
# Clock Output Source Selector

This block decides what a single clock-output pad carries. One 8-bit control register holds a 4-bit source code, a drive enable, a power-down flag and a 2-bit loop-divider code for an external PLL. Depending on the source code, the pad carries a general-purpose output value, the external PLL clock, a constant level, the crystal clock or one of its binary divisions, or a square wave that flips on each overflow pulse of a chosen timer.

Everything runs in the crystal clock domain. The divided clocks come from a free-running counter that is cleared by synchronous reset. The timer square wave comes from a toggle flop that restarts at 0 whenever software writes the register. The register also decodes the PLL loop-divider code into an integer for the PLL and passes the power-down flag straight through.

Top module: `ckout_sel_top`

## Requirements
- R1: After synchronous reset the register reads 00h. `pin_oe` is 0, `pin_out` follows `gpio_out`, `pll_pd` is 0 and `pll_fb_div` is 23.
- R2: A write with `wr_en` high takes effect on the next `xtal_clk` rising edge. Data bits [7:4] are the source code, bit 3 is the drive enable, bit 2 drives `pll_pd` and bits [1:0] are the loop-divider code.
- R3: `pll_fb_div` is 23 for loop-divider codes 0 and 3, 27 for code 1 and 28 for code 2.
- R4: Source code 0 releases the pad whatever the enable says: `pin_oe` = 0 and `pin_out` = `gpio_out`.
- R5: With the enable set, code 1 puts `pll_clk` on `pin_out` with `pin_oe` = 1.
- R6: With the enable set, code 2 holds `pin_out` at 0 and code 3 holds it at 1, both with `pin_oe` = 1.
- R7: With the enable set, code 4 outputs `xtal_clk` itself. Codes 5, 6 and 7 output bits 0, 1 and 2 of a counter that goes to 0 on reset and then adds one on every edge, which gives divide by 2, 4 and 8.
- R8: With the enable set, codes 8 to 11 output a toggle flop. The flop inverts on each cycle in which the overflow pulse of timer (code − 8) is high. Pulses from the other timers leave it unchanged.
- R9: Every register write clears the toggle flop on the same edge, and the clear wins over a coincident pulse. Until the write lands, toggling follows the old source code.
- R10: With the enable set, the reserved codes 12 to 15 drive `pin_out` = 0 with `pin_oe` = 1.
- R11: With the enable clear and any code other than 0, the block drives `pin_out` = 0 with `pin_oe` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Crystal clock; also a selectable source |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| tmr_ovf | input | 4 | One-cycle overflow pulses of timers 0 to 3 |
| pll_clk | input | 1 | Clock from the external PLL |
| gpio_out | input | 1 | General-purpose output value for code 0 |
| pin_out | output | 1 | Value driven toward the pad |
| pin_oe | output | 1 | Pad output enable |
| pll_pd | output | 1 | PLL power-down request |
| pll_fb_div | output | 5 | Decoded PLL loop divide value |

## Verification
The bench goes after the cases that are easy to get wrong.

- A write and the selected timer's pulse in the same cycle must leave the toggle at 0. A design that lets the pulse win shows a 1 where a freshly written code should start low.
- Code 0 with the enable clear must still release the pad. A design that applies the enable first would drive a 0 against the general-purpose value.
- The reserved codes and the last divider and timer codes check for an off-by-one slip in the mapping. Such a slip shows up as a wrong divided phase or a square wave on a reserved code.
- Loop-divider code 3 must alias to 23 and not to some fourth value.
- Each sample is taken with the crystal clock both high and low, so an inverted or registered pass-through of the crystal clock cannot go unnoticed.

// File: rtl/ckout_pkg.sv
package ckout_pkg;
   localparam int CK_REG_W   = 8;
   localparam int CK_SEL_W   = 4;
   localparam int CK_FB_W    = 5;

   localparam logic [CK_SEL_W-1:0] SRC_GPIO     = 4'h0;
   localparam logic [CK_SEL_W-1:0] SRC_PLL      = 4'h1;
   localparam logic [CK_SEL_W-1:0] SRC_LOW      = 4'h2;
   localparam logic [CK_SEL_W-1:0] SRC_HIGH     = 4'h3;
   localparam logic [CK_SEL_W-1:0] SRC_XTAL     = 4'h4;
   localparam logic [CK_SEL_W-1:0] SRC_DIV_BASE = 4'h5;
   localparam logic [CK_SEL_W-1:0] SRC_TMR_BASE = 4'h8;

   typedef struct packed {
      logic [CK_SEL_W-1:0] src;
      logic                drive_en;
      logic                pll_off;
      logic [1:0]          fb_code;
   } ck_ctrl_t;
endpackage

// File: rtl/ckout_ctrl_reg.sv
module ckout_ctrl_reg
   import ckout_pkg::*;
#(
   parameter int FB_W     = CK_FB_W,
   parameter int FB_DIV_A = 23,
   parameter int FB_DIV_B = 27,
   parameter int FB_DIV_C = 28
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_en,
   input  logic [CK_REG_W-1:0] wr_data,
   output ck_ctrl_t            ctrl,
   output logic [FB_W-1:0]     fb_div
);
   localparam int FB_MAX = (FB_DIV_A > FB_DIV_B) ?
                           ((FB_DIV_A > FB_DIV_C) ? FB_DIV_A : FB_DIV_C) :
                           ((FB_DIV_B > FB_DIV_C) ? FB_DIV_B : FB_DIV_C);

   if (FB_MAX >= (1 << FB_W)) begin : g_fb_w_chk
      $error("FB_W too narrow for the largest divide value");
   end
   if ($bits(ck_ctrl_t) != CK_REG_W) begin : g_reg_w_chk
      $error("control struct width must equal register width");
   end

   ck_ctrl_t ctrl_q;

   always_ff @(posedge clk) begin
      if (rst)        ctrl_q <= '0;
      else if (wr_en) ctrl_q <= ck_ctrl_t'(wr_data);
   end

   always_comb begin
      unique case (ctrl_q.fb_code)
         2'b01:   fb_div = FB_W'(FB_DIV_B);
         2'b10:   fb_div = FB_W'(FB_DIV_C);
         default: fb_div = FB_W'(FB_DIV_A);
      endcase
   end

   assign ctrl = ctrl_q;

   AST_WR_LANDS: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> ctrl_q == $past(ck_ctrl_t'(wr_data)));                 // R2
   AST_HOLD_NO_WR: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(ctrl_q));                                      // R2
   AST_FB_LEGAL: assert property (@(posedge clk) disable iff (rst)
      fb_div == FB_W'(FB_DIV_A) || fb_div == FB_W'(FB_DIV_B) ||
      fb_div == FB_W'(FB_DIV_C));                                       // R3
endmodule

// File: rtl/ckout_div_chain.sv
module ckout_div_chain #(
   parameter int STAGES = 3
) (
   input  logic              clk,
   input  logic              rst,
   output logic [STAGES-1:0] taps
);
   if (STAGES < 1 || STAGES > 16) begin : g_stage_chk
      $error("STAGES out of range");
   end

   logic [STAGES-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + 1'b1;
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_tap
      assign taps[i] = cnt_q[i];
   end

   AST_DIV_STEP: assert property (@(posedge clk) disable iff (rst)
      !rst |=> cnt_q == $past(cnt_q) + 1'b1);                          // R7
   AST_DIV_LSB_FLIPS: assert property (@(posedge clk) disable iff (rst)
      !rst |=> taps[0] != $past(taps[0]));                              // R7
endmodule

// File: rtl/ckout_tmr_toggle.sv
module ckout_tmr_toggle #(
   parameter int NUM_TMR = 4,
   parameter int IDX_W   = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic               armed,
   input  logic [IDX_W-1:0]   idx,
   input  logic [NUM_TMR-1:0] tmr_ovf,
   output logic               tgl
);
   if (NUM_TMR < 1) begin : g_tmr_chk
      $error("NUM_TMR must be at least one");
   end

   logic tgl_q;
   logic hit;

   assign hit = armed && (32'(idx) < NUM_TMR) && tmr_ovf[idx];

   always_ff @(posedge clk) begin
      if (rst)        tgl_q <= 1'b0;
      else if (wr_en) tgl_q <= 1'b0;
      else if (hit)   tgl_q <= ~tgl_q;
   end

   assign tgl = tgl_q;

   AST_TGL_CLEAR: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> !tgl);                                                  // R9
   AST_TGL_QUIET: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && !(|tmr_ovf)) |=> $stable(tgl));                        // R8
   AST_TGL_DISARMED: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && !armed) |=> $stable(tgl));                             // R8
endmodule

// File: rtl/ckout_src_mux.sv
module ckout_src_mux
   import ckout_pkg::*;
#(
   parameter int STAGES  = 3,
   parameter int NUM_TMR = 4
) (
   input  logic [CK_SEL_W-1:0] src,
   input  logic                drive_en,
   input  logic                xtal_clk,
   input  logic                pll_clk,
   input  logic                gpio_out,
   input  logic [STAGES-1:0]   taps,
   input  logic                tgl,
   output logic                pin_out,
   output logic                pin_oe
);
   localparam int DIV_LO = int'(SRC_DIV_BASE);
   localparam int TMR_LO = int'(SRC_TMR_BASE);

   if (DIV_LO + STAGES > TMR_LO) begin : g_div_room
      $error("divider codes overlap timer codes");
   end
   if (TMR_LO + NUM_TMR > (1 << CK_SEL_W)) begin : g_tmr_room
      $error("timer codes exceed select field");
   end

   logic div_hit, div_val;

   always_comb begin
      div_hit = 1'b0;
      div_val = 1'b0;
      for (int i = 0; i < STAGES; i++) begin
         if (32'(src) == DIV_LO + i) begin
            div_hit = 1'b1;
            div_val = taps[i];
         end
      end
   end

   always_comb begin
      pin_oe  = 1'b1;
      pin_out = 1'b0;
      if (src == SRC_GPIO) begin
         pin_oe  = 1'b0;
         pin_out = gpio_out;
      end else if (drive_en) begin
         if (src == SRC_PLL)                    pin_out = pll_clk;
         else if (src == SRC_HIGH)              pin_out = 1'b1;
         else if (src == SRC_XTAL)              pin_out = xtal_clk;
         else if (div_hit)                      pin_out = div_val;
         else if (32'(src) >= TMR_LO &&
                  32'(src) <  TMR_LO + NUM_TMR) pin_out = tgl;
      end
   end
endmodule

// File: rtl/ckout_sel_top.sv
module ckout_sel_top
   import ckout_pkg::*;
#(
   parameter int STAGES  = 3,
   parameter int NUM_TMR = 4,
   parameter int FB_W    = CK_FB_W
) (
   input  logic                xtal_clk,
   input  logic                rst,
   input  logic                wr_en,
   input  logic [CK_REG_W-1:0] wr_data,
   input  logic [NUM_TMR-1:0]  tmr_ovf,
   input  logic                pll_clk,
   input  logic                gpio_out,
   output logic                pin_out,
   output logic                pin_oe,
   output logic                pll_pd,
   output logic [FB_W-1:0]     pll_fb_div
);
   localparam int IDX_W = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

   ck_ctrl_t          ctrl;
   logic [STAGES-1:0] taps;
   logic              tgl;
   logic              armed;
   logic [IDX_W-1:0]  tmr_idx;
   logic [CK_SEL_W-1:0] rel;

   assign rel     = ctrl.src - SRC_TMR_BASE;
   assign armed   = (ctrl.src >= SRC_TMR_BASE) && (32'(rel) < NUM_TMR);
   assign tmr_idx = rel[IDX_W-1:0];

   ckout_ctrl_reg #(.FB_W(FB_W)) u_reg (
      .clk(xtal_clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .ctrl(ctrl), .fb_div(pll_fb_div));

   ckout_div_chain #(.STAGES(STAGES)) u_div (
      .clk(xtal_clk), .rst(rst), .taps(taps));

   ckout_tmr_toggle #(.NUM_TMR(NUM_TMR), .IDX_W(IDX_W)) u_tgl (
      .clk(xtal_clk), .rst(rst), .wr_en(wr_en), .armed(armed),
      .idx(tmr_idx), .tmr_ovf(tmr_ovf), .tgl(tgl));

   ckout_src_mux #(.STAGES(STAGES), .NUM_TMR(NUM_TMR)) u_mux (
      .src(ctrl.src), .drive_en(ctrl.drive_en), .xtal_clk(xtal_clk),
      .pll_clk(pll_clk), .gpio_out(gpio_out), .taps(taps), .tgl(tgl),
      .pin_out(pin_out), .pin_oe(pin_oe));

   assign pll_pd = ctrl.pll_off;

   AST_GPIO_HANDOFF: assert property (@(posedge xtal_clk) disable iff (rst)
      !pin_oe |-> pin_out == gpio_out);                                 // R4
   AST_OFF_LOW: assert property (@(posedge xtal_clk) disable iff (rst)
      (!ctrl.drive_en && ctrl.src != SRC_GPIO) |-> (pin_oe && !pin_out)); // R11
   AST_RSVD_LOW: assert property (@(posedge xtal_clk) disable iff (rst)
      (ctrl.src >= 4'hC) |-> (pin_oe && !pin_out));                     // R10
   AST_RESET_RELEASE: assert property (@(posedge xtal_clk)
      rst |=> (!pin_oe && !pll_pd));                                    // R1
endmodule

// File: tb/ckout_sel_top_tb.sv
module ckout_sel_top_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [3:0] tmr_ovf = '0;
   logic       pll_clk = 1'b0;
   logic       gpio_out = 1'b0;
   logic       pin_out, pin_oe, pll_pd;
   logic [4:0] pll_fb_div;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [7:0] m_reg = '0;
   logic [2:0] m_cnt = '0;
   logic       m_tgl = 1'b0;

   always #4 clk = ~clk;

   ckout_sel_top u_dut (
      .xtal_clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .tmr_ovf(tmr_ovf), .pll_clk(pll_clk), .gpio_out(gpio_out),
      .pin_out(pin_out), .pin_oe(pin_oe), .pll_pd(pll_pd),
      .pll_fb_div(pll_fb_div));

   function automatic logic [4:0] exp_fb(input logic [1:0] c);
      return (c == 2'b01) ? 5'd27 : (c == 2'b10) ? 5'd28 : 5'd23;
   endfunction

   // returns {oe, pin}
   function automatic logic [1:0] exp_pin(input logic [7:0] r, input logic [2:0] c,
                                          input logic t, input logic ck,
                                          input logic p, input logic g);
      logic [3:0] s = r[7:4];
      if (s == 4'h0) return {1'b0, g};
      if (!r[3]) return 2'b10;
      case (s)
         4'h1: return {1'b1, p};
         4'h2: return 2'b10;
         4'h3: return 2'b11;
         4'h4: return {1'b1, ck};
         4'h5: return {1'b1, c[0]};
         4'h6: return {1'b1, c[1]};
         4'h7: return {1'b1, c[2]};
         4'h8, 4'h9, 4'hA, 4'hB: return {1'b1, t};
         default: return 2'b10;
      endcase
   endfunction

   function automatic string req_of(input logic [7:0] r);
      logic [3:0] s = r[7:4];
      if (s == 4'h0) return "R4";
      if (!r[3]) return "R11";
      if (s == 4'h1) return "R5";
      if (s == 4'h2 || s == 4'h3) return "R6";
      if (s >= 4'h4 && s <= 4'h7) return "R7";
      if (s >= 4'h8 && s <= 4'hB) return "R8 R9";
      return "R10";
   endfunction

   task automatic check(input string req, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
      end
   endtask

   task automatic check_all(input logic ck);
      logic [1:0] e = exp_pin(m_reg, m_cnt, m_tgl, ck, pll_clk, gpio_out);
      check(req_of(m_reg), {pin_oe, pin_out}, e);
      check("R2", pll_pd, m_reg[2]);
      check("R3", pll_fb_div, exp_fb(m_reg[1:0]));
   endtask

   // model of one rising edge, old register selects the timer (R9)
   task automatic model_edge();
      if (rst) begin
         m_reg = '0; m_cnt = '0; m_tgl = 1'b0;
      end else begin
         if (wr_en) m_tgl = 1'b0;
         else if (m_reg[7:4] >= 4'h8 && m_reg[7:4] <= 4'hB &&
                  tmr_ovf[m_reg[5:4]]) m_tgl = ~m_tgl;
         m_cnt = m_cnt + 3'd1;
         if (wr_en) m_reg = wr_data;
      end
   endtask

   task automatic cycle();
      @(posedge clk);
      model_edge();
      #2 check_all(1'b1);
      @(negedge clk);
      #1 check_all(1'b0);
   endtask

   task automatic drive(input logic w, input logic [7:0] d, input logic [3:0] t);
      wr_en = w; wr_data = d; tmr_ovf = t;
      pll_clk = 1'($urandom); gpio_out = 1'($urandom);
   endtask

   initial begin
      void'($urandom(32'd4242));
      drive(1'b0, 8'h00, 4'h0);
      rst = 1'b1;
      repeat (3) cycle();
      rst = 1'b0;
      cycle();
      // R1: reset state
      check("R1", {pin_oe, pin_out, pll_pd, pll_fb_div}, {1'b0, gpio_out, 1'b0, 5'd23});

      // every code with enable on and off (R4 R5 R6 R7 R10 R11)
      for (int s = 0; s < 16; s++) begin
         for (int en = 0; en < 2; en++) begin
            drive(1'b1, {4'(s), 1'(en), 1'(s & 1), 2'(s)}, 4'h0);
            cycle();
            for (int k = 0; k < 9; k++) begin
               drive(1'b0, 8'h00, 4'($urandom));
               cycle();
            end
         end
      end

      // R8: only the selected timer toggles
      drive(1'b1, 8'h98, 4'h0); cycle();
      drive(1'b0, 8'h00, 4'b0010); cycle();
      check("R8", pin_out, 1);
      drive(1'b0, 8'h00, 4'b1101); cycle();
      check("R8", pin_out, 1);
      // R9: write coinciding with selected pulse clears
      drive(1'b1, 8'h98, 4'b0010); cycle();
      check("R9", pin_out, 0);
      // R9: toggling follows the old code until the write lands
      drive(1'b1, 8'hB8, 4'b0010); cycle();
      check("R9", pin_out, 0);
      drive(1'b0, 8'h00, 4'b1000); cycle();
      check("R9", pin_out, 1);

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         drive(($urandom % 6) == 0, 8'($urandom), 4'($urandom) & 4'($urandom));
         cycle();
      end

      // R1: reset mid-run
      drive(1'b0, 8'h00, 4'h0);
      rst = 1'b1; cycle(); rst = 1'b0; cycle();
      check("R1", {pin_oe, pll_pd}, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule